// File: doc/BRIEF.md
# SPI Burst Frame Sequencer

This block is the transfer engine of a master-mode SPI controller. It pulls words from a transmit queue, shifts each out as one frame on a serial clock and data line, captures the word coming back on the input line, and hands that word to a receive queue. A single active-low select line frames the traffic. Software sets a burst length in the control word. The sequencer counts frames against that length and reports the end of each burst to the interrupt logic. At the end of a burst the count reloads, so the next burst can follow with no further set-up.

The select line can behave in two ways. It can stay low from the first frame of a burst to the last, even when the transmit queue runs dry part way through. It can also rise between every pair of frames. The control, frame-size and divider registers are held in this block and exposed for read-back. A control write with the top bit set returns the whole block to its reset state.

Top module: `spi_frame_seq`

## Requirements
- R1: After reset `ctrlQ` = 0x80000102, `sizeQ` = 4, `divQ` = 7, `csN` = 1, `sclk` = 0, and `stDone`, `stReady`, `rawDone`, `rawReady` and `donePulse` are all 0.
- R2: A control write with bit 31 set aborts any frame in flight. It then restores every value listed in R1 one cycle later.
- R3: A frame starts, with `txPop` high for exactly one cycle, only when control bit 0 (enable) is 1, `txValid` is 1 and the frame counter is non-zero. The counter is loaded from control bits [23:8] on every control write.
- R4: Each frame drives the low `sizeQ` bits of the popped word MSB first on `mosi`, mode 0. Data changes on the falling `sclk` edge and is sampled on the rising edge, and `sclk` idles low while `csN` is high. The `sizeQ` bits sampled from `miso` arrive right-aligned on `rxData`, with `rxPush` high for one cycle at frame end.
- R5: Each `sclk` high phase and low phase lasts `divQ`+1 clock cycles.
- R6: With control bit 26 (hold) at 0, `csN` rises after every frame, so a burst of N frames shows N rising edges on `csN`.
- R7: With hold at 1, `csN` stays low from the first to the last frame of a burst. This includes cycles when `txValid` is 0. It rises once, when the burst ends.
- R8: When the last frame of a burst ends, `donePulse` is high for one cycle and `csN` goes high. `stDone`, `stReady`, `rawDone` and `rawReady` are set, and the counter reloads from control bits [23:8], so the next burst runs without a new control write.
- R9: `stDone` and `stReady` clear when a frame starts. `rawDone` and `rawReady` hold until cleared by `intClr` bit 0 and bit 1 respectively.
- R10: A frame-size write is ignored while enable is 1, or when the value is 0 or above 32. Otherwise `sizeQ` takes the value.
- R11: A control write while no frame is in flight drives `csN` high. This ends a held selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 32 | Control write data (bit0 enable, bit26 hold, [23:8] count, bit31 soft reset) |
| sizeWe | input | 1 | Frame-size write strobe |
| sizeWdata | input | SIZE_W | Frame size in bits, 1 to DATA_W |
| divWe | input | 1 | Divider write strobe |
| divWdata | input | DIV_W | Divider value; half period is value+1 clocks |
| intClr | input | 2 | Clear raw done (bit0) and raw ready (bit1) |
| txValid | input | 1 | Transmit queue not empty |
| txData | input | DATA_W | Head of transmit queue |
| txPop | output | 1 | Remove head of transmit queue |
| rxPush | output | 1 | Received word valid, one cycle |
| rxData | output | DATA_W | Received word, right-aligned |
| miso | input | 1 | Serial data from the target |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the target |
| csN | output | 1 | Active-low select line 0 |
| donePulse | output | 1 | End of burst event |
| stDone | output | 1 | Status: transfer done |
| stReady | output | 1 | Status: receive ready |
| rawDone | output | 1 | Raw interrupt: transfer done |
| rawReady | output | 1 | Raw interrupt: receive ready |
| ctrlQ | output | 32 | Control register value |
| sizeQ | output | SIZE_W | Frame-size register value |
| divQ | output | DIV_W | Divider register value |

## Verification
The assertions check these rules on every cycle:
- `sclk` stays low while deselected.
- `mosi` holds steady through a high clock phase.
- Each pop is followed by an asserted select with cleared status bits.
- Each burst-end pulse coincides with all four done flags and a raised select.

Some behaviour can only be shown by the bench's scenarios:
- The bit order and the right-alignment of received words.
- The exact half-period length.
- The number of select edges per burst in each hold mode.
- A burst surviving an empty queue.
- Counter reload across back-to-back bursts.
- The ignored size writes.
- The soft-reset abort.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam logic [31:0] CTRL_RESET = 32'h8000_0102;
  localparam int BIT_EN   = 0;
  localparam int BIT_HOLD = 26;
  localparam int BIT_SRST = 31;
  localparam int CNT_LSB  = 8;
  localparam int CNT_W    = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_HIGH, ST_LOW} seqState_t;

  typedef struct packed {
    logic load;    // capture a new tx word
    logic sample;  // take one miso bit (rising sclk)
    logic shift;   // advance mosi (falling sclk)
  } seqStrobe_t;
endpackage

// File: rtl/spi_seq_dp.sv
module spi_seq_dp
  import spi_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SIZE_W = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [SIZE_W-1:0] frameSize,
  input  logic [DATA_W-1:0] txData,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] rxReg;
  logic [SIZE_W-1:0] padBits;

  assign padBits = SIZE_W'(DATA_W) - frameSize;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      rxReg <= '0;
    end else begin
      if (strobe.load) begin
        shReg <= txData << padBits;
        rxReg <= '0;
      end else begin
        if (strobe.sample) rxReg <= {rxReg[DATA_W-2:0], miso};
        if (strobe.shift)  shReg <= {shReg[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign mosi   = shReg[DATA_W-1];
  assign rxData = rxReg;
endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  localparam int SIZE_W = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [31:0]       ctrlWdata,
  input  logic              sizeWe,
  input  logic [SIZE_W-1:0] sizeWdata,
  input  logic              divWe,
  input  logic [DIV_W-1:0]  divWdata,
  input  logic [1:0]        intClr,
  input  logic              txValid,
  output logic              txPop,
  output seqStrobe_t        strobe,
  output logic              sclk,
  output logic              csN,
  output logic              rxPush,
  output logic              donePulse,
  output logic              stDone,
  output logic              stReady,
  output logic              rawDone,
  output logic              rawReady,
  output logic [31:0]       ctrlQ,
  output logic [SIZE_W-1:0] sizeQ,
  output logic [DIV_W-1:0]  divQ
);
  seqState_t         state;
  logic [DIV_W-1:0]  divCnt;
  logic [SIZE_W-1:0] bitCnt;
  logic [CNT_W-1:0]  frameCnt;
  logic              tick, softRst, loadOk, lastBit;

  assign softRst = ctrlWe && ctrlWdata[BIT_SRST];
  assign tick    = (divCnt == divQ);
  assign lastBit = (bitCnt == sizeQ);
  assign loadOk  = (state == ST_IDLE) && ctrlQ[BIT_EN] && txValid &&
                   (frameCnt != '0) && !ctrlWe;
  assign txPop   = loadOk;

  always_comb begin
    strobe.load   = loadOk;
    strobe.sample = tick && ((state == ST_LEAD) || (state == ST_LOW && !lastBit));
    strobe.shift  = tick && (state == ST_HIGH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= CTRL_RESET;  sizeQ <= SIZE_W'(4);  divQ <= DIV_W'(7);
      frameCnt <= CTRL_RESET[CNT_LSB +: CNT_W];
      state <= ST_IDLE;  divCnt <= '0;  bitCnt <= '0;
      sclk <= 1'b0;  csN <= 1'b1;  rxPush <= 1'b0;  donePulse <= 1'b0;
      stDone <= 1'b0;  stReady <= 1'b0;  rawDone <= 1'b0;  rawReady <= 1'b0;
    end else if (softRst) begin
      ctrlQ <= CTRL_RESET;  sizeQ <= SIZE_W'(4);  divQ <= DIV_W'(7);
      frameCnt <= CTRL_RESET[CNT_LSB +: CNT_W];
      state <= ST_IDLE;  divCnt <= '0;  bitCnt <= '0;
      sclk <= 1'b0;  csN <= 1'b1;  rxPush <= 1'b0;  donePulse <= 1'b0;
      stDone <= 1'b0;  stReady <= 1'b0;  rawDone <= 1'b0;  rawReady <= 1'b0;
    end else begin
      rxPush    <= 1'b0;
      donePulse <= 1'b0;
      if (intClr[0]) rawDone  <= 1'b0;
      if (intClr[1]) rawReady <= 1'b0;
      if (state != ST_IDLE) divCnt <= tick ? '0 : divCnt + 1'b1;

      unique case (state)
        ST_IDLE: if (loadOk) begin
          csN <= 1'b0;  stDone <= 1'b0;  stReady <= 1'b0;
          bitCnt <= '0;  divCnt <= '0;  state <= ST_LEAD;
        end
        ST_LEAD: if (tick) begin
          sclk <= 1'b1;  bitCnt <= bitCnt + 1'b1;  state <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          sclk <= 1'b0;  state <= ST_LOW;
        end
        ST_LOW: if (tick) begin
          if (lastBit) begin
            rxPush <= 1'b1;
            state  <= ST_IDLE;
            if (frameCnt == CNT_W'(1)) begin
              frameCnt  <= ctrlQ[CNT_LSB +: CNT_W];
              csN       <= 1'b1;
              donePulse <= 1'b1;
              stDone <= 1'b1;  stReady <= 1'b1;
              rawDone <= 1'b1; rawReady <= 1'b1;
            end else begin
              frameCnt <= frameCnt - 1'b1;
              if (!ctrlQ[BIT_HOLD]) csN <= 1'b1;
            end
          end else begin
            sclk <= 1'b1;  bitCnt <= bitCnt + 1'b1;  state <= ST_HIGH;
          end
        end
        default: state <= ST_IDLE;
      endcase

      if (ctrlWe) begin
        ctrlQ    <= ctrlWdata;
        frameCnt <= ctrlWdata[CNT_LSB +: CNT_W];
        if (state == ST_IDLE) csN <= 1'b1;
      end
      if (sizeWe && !ctrlQ[BIT_EN] && (sizeWdata != '0) &&
          (sizeWdata <= SIZE_W'(DATA_W)))
        sizeQ <= sizeWdata;
      if (divWe) divQ <= divWdata;
    end
  end
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  localparam int SIZE_W = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [31:0]       ctrlWdata,
  input  logic              sizeWe,
  input  logic [SIZE_W-1:0] sizeWdata,
  input  logic              divWe,
  input  logic [DIV_W-1:0]  divWdata,
  input  logic [1:0]        intClr,
  input  logic              txValid,
  input  logic [DATA_W-1:0] txData,
  output logic              txPop,
  output logic              rxPush,
  output logic [DATA_W-1:0] rxData,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              csN,
  output logic              donePulse,
  output logic              stDone,
  output logic              stReady,
  output logic              rawDone,
  output logic              rawReady,
  output logic [31:0]       ctrlQ,
  output logic [SIZE_W-1:0] sizeQ,
  output logic [DIV_W-1:0]  divQ
);
  seqStrobe_t strobe;

  spi_seq_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .sizeWe(sizeWe), .sizeWdata(sizeWdata), .divWe(divWe), .divWdata(divWdata),
    .intClr(intClr), .txValid(txValid), .txPop(txPop), .strobe(strobe),
    .sclk(sclk), .csN(csN), .rxPush(rxPush), .donePulse(donePulse),
    .stDone(stDone), .stReady(stReady), .rawDone(rawDone), .rawReady(rawReady),
    .ctrlQ(ctrlQ), .sizeQ(sizeQ), .divQ(divQ)
  );

  spi_seq_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .frameSize(sizeQ),
    .txData(txData), .miso(miso), .mosi(mosi), .rxData(rxData)
  );
endmodule

// File: rtl/spi_frame_seq_chk.sv
module spi_frame_seq_chk (
  input logic clk,
  input logic rstN,
  input logic txPop,
  input logic rxPush,
  input logic sclk,
  input logic mosi,
  input logic csN,
  input logic donePulse,
  input logic stDone,
  input logic stReady,
  input logic rawDone,
  input logic rawReady
);
  // R4: the serial clock only moves while the target is selected
  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R4: output data is held steady while sclk is high
  assert_mosi_steady_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R4: one push per frame end
  assert_push_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |=> !rxPush);

  // R3: a pop starts a frame by selecting the target
  assert_pop_selects_R3: assert property (@(posedge clk) disable iff (!rstN)
    txPop |=> !csN);

  // R9: frame start clears the general status bits
  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    txPop |=> (!stDone && !stReady));

  // R8: burst end raises all done flags and deselects
  assert_done_flags_R8: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (stDone && stReady && rawDone && rawReady && csN));

  // R8: burst-end event lasts one cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);
endmodule

bind spi_frame_seq spi_frame_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .txPop(txPop), .rxPush(rxPush), .sclk(sclk),
  .mosi(mosi), .csN(csN), .donePulse(donePulse), .stDone(stDone),
  .stReady(stReady), .rawDone(rawDone), .rawReady(rawReady)
);

// File: tb/tb_spi_frame_seq.sv
module tb_spi_frame_seq;
  localparam int DATA_W = 32;
  localparam int DIV_W  = 8;
  localparam int SIZE_W = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic ctrlWe = 0, sizeWe = 0, divWe = 0;
  logic [31:0] ctrlWdata = '0;
  logic [SIZE_W-1:0] sizeWdata = '0;
  logic [DIV_W-1:0] divWdata = '0;
  logic [1:0] intClr = '0;
  logic txValid, txPop, rxPush, sclk, mosi, csN, donePulse;
  logic [DATA_W-1:0] txData, rxData;
  logic miso = 1'b0;
  logic stDone, stReady, rawDone, rawReady;
  logic [31:0] ctrlQ;
  logic [SIZE_W-1:0] sizeQ;
  logic [DIV_W-1:0] divQ;

  always #5 clk = ~clk;

  spi_frame_seq #(.DATA_W(DATA_W), .DIV_W(DIV_W)) dut (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .sizeWe(sizeWe), .sizeWdata(sizeWdata), .divWe(divWe), .divWdata(divWdata),
    .intClr(intClr), .txValid(txValid), .txData(txData), .txPop(txPop),
    .rxPush(rxPush), .rxData(rxData), .miso(miso), .sclk(sclk), .mosi(mosi),
    .csN(csN), .donePulse(donePulse), .stDone(stDone), .stReady(stReady),
    .rawDone(rawDone), .rawReady(rawReady), .ctrlQ(ctrlQ), .sizeQ(sizeQ),
    .divQ(divQ)
  );

  int errors = 0, checks = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // transmit queue model
  logic [31:0] txMem [64];
  int txHead = 0, txTail = 0;
  assign txValid = (txHead != txTail);
  assign txData  = txMem[txHead % 64];
  always @(posedge clk) if (txPop) txHead <= txHead + 1;

  // monitors
  int csFalls = 0, csRises = 0, doneCnt = 0, rxN = 0, hiRun = 0, lastHi = 0;
  logic [31:0] rxWords [64];
  always @(negedge csN) if (rstN) csFalls++;
  always @(posedge csN) if (rstN) csRises++;
  always @(posedge clk) begin
    if (donePulse) doneCnt++;
    if (rxPush) begin rxWords[rxN % 64] = rxData; rxN++; end
    if (sclk) hiRun++;
    else if (hiRun != 0) begin lastHi = hiRun; hiRun = 0; end
  end

  // target model
  int curSize = 4, sBits = 0, sFrame = 0, slvN = 0;
  logic [31:0] sIn = '0;
  logic [31:0] slvGot [64];

  function automatic logic [31:0] maskOf(input int size);
    return (size >= 32) ? 32'hFFFF_FFFF : ((32'd1 << size) - 1);
  endfunction
  function automatic logic [31:0] resp(input int n, input int size);
    return (32'(n) * 32'h9E37_79B9 + 32'h0123_4567) & maskOf(size);
  endfunction

  always @(posedge sclk) begin
    sIn = {sIn[30:0], mosi};
    sBits++;
    if (sBits == curSize) begin
      slvGot[slvN % 64] = sIn & maskOf(curSize);
      slvN++; sBits = 0; sFrame++;
    end
  end
  always @(negedge sclk) begin
    logic [31:0] r;
    r = resp(sFrame, curSize);
    miso = r[curSize-1-sBits];
  end

  task automatic resetTarget(input int size);
    logic [31:0] r;
    curSize = size; sBits = 0; sFrame = 0; slvN = 0; rxN = 0;
    csFalls = 0; csRises = 0; doneCnt = 0;
    r = resp(0, size);
    miso = r[size-1];
  endtask

  task automatic wrCtrl(input logic [31:0] v);
    @(negedge clk); ctrlWe = 1; ctrlWdata = v;
    @(negedge clk); ctrlWe = 0;
  endtask
  task automatic wrSize(input int v);
    @(negedge clk); sizeWe = 1; sizeWdata = SIZE_W'(v);
    @(negedge clk); sizeWe = 0;
  endtask
  task automatic wrDiv(input int v);
    @(negedge clk); divWe = 1; divWdata = DIV_W'(v);
    @(negedge clk); divWe = 0;
  endtask
  task automatic pushTx(input logic [31:0] w);
    @(negedge clk); txMem[txTail % 64] = w; txTail++;
  endtask
  task automatic waitDone(input int target);
    for (int i = 0; i < 20000 && doneCnt < target; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] ctrlWord(input int cnt, input bit hold);
    return 32'h1 | (32'(hold) << 26) | (32'(cnt) << 8);
  endfunction

  logic [31:0] expTx [64];

  // one or more bursts, checked word by word
  task automatic runBurst(input int size, input int div, input int cnt,
                          input bit hold, input int bursts);
    int n;
    n = cnt * bursts;
    wrCtrl(32'h0000_0100);
    wrSize(size); wrDiv(div);
    resetTarget(size);
    wrCtrl(ctrlWord(cnt, hold));
    for (int i = 0; i < n; i++) begin
      expTx[i] = $urandom;
      pushTx(expTx[i]);
    end
    waitDone(bursts);
    chk(slvN == n, "R4 frame count at target", slvN, n);
    for (int i = 0; i < n; i++) begin
      chk(slvGot[i] == (expTx[i] & maskOf(size)), "R4 mosi word",
          slvGot[i], expTx[i] & maskOf(size));
      chk(rxWords[i] == resp(i, size), "R4 rxData word", rxWords[i], resp(i, size));
    end
    chk(lastHi == div + 1, "R5 sclk half period", lastHi, div + 1);
    chk(csRises == (hold ? bursts : n), hold ? "R7 select edges" : "R6 select edges",
        csRises, hold ? bursts : n);
    chk(doneCnt == bursts, "R8 burst done count", doneCnt, bursts);
    chk(stDone && stReady && rawDone && rawReady, "R8 done flags",
        {stDone, stReady, rawDone, rawReady}, 4'hF);
    @(negedge clk); intClr = 2'b11; @(negedge clk); intClr = 2'b00;
  endtask

  initial begin
    repeat (1500000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ctrlQ == 32'h8000_0102, "R1 ctrl reset", ctrlQ, 32'h8000_0102);
    chk(sizeQ == 4, "R1 size reset", sizeQ, 4);
    chk(divQ == 7, "R1 div reset", divQ, 7);
    chk(csN == 1 && sclk == 0, "R1 pins idle", {csN, sclk}, 2'b10);
    chk({stDone, stReady, rawDone, rawReady, donePulse} == 0, "R1 flags clear",
        {stDone, stReady, rawDone, rawReady, donePulse}, 0);

    // R3 gating: enable off, then zero count
    resetTarget(4);
    wrCtrl(32'h0000_0200);
    pushTx(32'hA5);
    repeat (100) @(negedge clk);
    chk(slvN == 0 && csN == 1, "R3 no frame when disabled", slvN, 0);
    chk(txHead != txTail, "R3 queue untouched when disabled", txTail - txHead, 1);
    wrCtrl(32'h0000_0001);
    repeat (100) @(negedge clk);
    chk(slvN == 0, "R3 no frame with zero count", slvN, 0);
    wrCtrl(ctrlWord(1, 0));
    waitDone(1);
    chk(slvN == 1 && slvGot[0] == 32'h5, "R3 frame after count set", slvGot[0], 32'h5);

    // directed bursts
    runBurst(8, 1, 3, 0, 1);
    runBurst(32, 0, 2, 1, 1);
    runBurst(1, 2, 2, 0, 2);
    runBurst(16, 3, 2, 1, 2);

    // R7 hold through an empty queue, R11 release by control write
    wrCtrl(32'h0000_0100); wrSize(8); wrDiv(0);
    resetTarget(8);
    wrCtrl(ctrlWord(4, 1));
    pushTx(32'h11); pushTx(32'h22);
    repeat (200) @(negedge clk);
    chk(csN == 0, "R7 select held while queue empty", csN, 0);
    chk(doneCnt == 0 && csRises == 0, "R7 no early end", csRises, 0);
    pushTx(32'h33); pushTx(32'h44);
    waitDone(1);
    chk(csRises == 1 && csFalls == 1, "R7 single select window", csRises, 1);
    chk(slvGot[3] == 32'h44, "R7 last word", slvGot[3], 32'h44);
    resetTarget(8);
    wrCtrl(ctrlWord(3, 1));
    pushTx(32'h5A);
    repeat (60) @(negedge clk);
    chk(csN == 0, "R11 held before write", csN, 0);
    wrCtrl(ctrlWord(3, 1) & ~32'h1);
    chk(csN == 1, "R11 control write releases select", csN, 1);

    // R9 general status clears on start, raw persists
    wrSize(8); wrDiv(3);
    resetTarget(8);
    wrCtrl(ctrlWord(1, 0));
    pushTx(32'h77);
    waitDone(1);
    resetTarget(8);
    pushTx(32'h78);
    for (int i = 0; i < 50 && csN; i++) @(negedge clk);
    chk(!stDone && !stReady, "R9 status cleared at start", {stDone, stReady}, 0);
    chk(rawDone && rawReady, "R9 raw kept", {rawDone, rawReady}, 2'b11);
    waitDone(1);
    @(negedge clk); intClr = 2'b01; @(negedge clk); intClr = 2'b00;
    chk(!rawDone && rawReady, "R9 clear bit0 only", {rawDone, rawReady}, 2'b01);
    @(negedge clk); intClr = 2'b10; @(negedge clk); intClr = 2'b00;
    chk(!rawReady, "R9 clear bit1", rawReady, 0);

    // R10 size write filtering
    wrSize(12);
    chk(sizeQ == 8, "R10 size ignored while enabled", sizeQ, 8);
    wrCtrl(32'h0000_0100);
    wrSize(40);
    chk(sizeQ == 8, "R10 size above 32 ignored", sizeQ, 8);
    wrSize(0);
    chk(sizeQ == 8, "R10 size zero ignored", sizeQ, 8);
    wrSize(32);
    chk(sizeQ == 32, "R10 size 32 accepted", sizeQ, 32);

    // constrained random bursts
    for (int k = 0; k < 8; k++) begin
      runBurst($urandom_range(32, 1), $urandom_range(3, 0), $urandom_range(4, 1),
               1'($urandom_range(1, 0)), $urandom_range(2, 1));
    end

    // R2 soft reset mid-frame
    wrCtrl(32'h0000_0100); wrSize(16); wrDiv(3);
    resetTarget(16);
    wrCtrl(ctrlWord(1, 1));
    pushTx(32'hBEEF);
    for (int i = 0; i < 200 && !sclk; i++) @(negedge clk);
    @(negedge clk); ctrlWe = 1; ctrlWdata = 32'h8000_0000;
    @(negedge clk); ctrlWe = 0;
    chk(csN == 1 && sclk == 0, "R2 pins after soft reset", {csN, sclk}, 2'b10);
    chk(ctrlQ == 32'h8000_0102, "R2 ctrl after soft reset", ctrlQ, 32'h8000_0102);
    chk(sizeQ == 4 && divQ == 7, "R2 size/div after soft reset", {sizeQ, divQ}, {6'd4, 8'd7});
    repeat (100) @(negedge clk);
    chk(csN == 1 && rxN == 0, "R2 frame aborted", rxN, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule